// File: doc/BRIEF.md
# Packed byte dot-product accumulator

This block is a SIMD datapath. For every 32-bit lane it multiplies four byte pairs, adds the four products to a 32-bit accumulator lane and returns the packed 32-bit lane results. Two byte vectors supply the factors. A third vector of 32-bit lanes supplies the addends. Three things are chosen per beat: the signedness of the byte operands (both signed, signed by unsigned, or both unsigned), whether the lane sum wraps or clamps, and whether only the lower half of the lanes is active.

One beat is accepted per cycle through a valid/ready input handshake. The result leaves through one register stage that has a valid/ready output. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds and no new beat is taken. Full throughput needs no bubble cycles.

Top module: `byte_dot_acc`

## Requirements
- R1: Result lane j, in bits 32j+31:32j, combines bytes 4j to 4j+3 of `a_vec` with the bytes in the same positions of `b_vec`. Byte k sits in bits 8k+7:8k.
- R2: With `op_kind` = 0, both bytes are sign-extended before they are multiplied.
- R3: With `op_kind` = 1, the `a_vec` byte is sign-extended, the `b_vec` byte is zero-extended and the product is signed.
- R4: With `op_kind` = 2 or 3, both bytes are zero-extended. Code 3 behaves exactly as code 2.
- R5: With `sat_en` = 0, a result lane is the accumulator lane plus the four products, taken modulo 2^32.
- R6: With `sat_en` = 1 and `op_kind` 0 or 1, the exact sum is clamped to the range 0x80000000..0x7FFFFFFF, read as signed.
- R7: With `sat_en` = 1 and `op_kind` 2 or 3, the accumulator lane is read as unsigned and the exact sum is clamped to 0..0xFFFFFFFF.
- R8: With `narrow` = 1, only lanes 0 to LANES/2-1 are computed. The upper half of `out_data` is zero and the upper halves of the operands have no effect.
- R9: A beat accepted on one rising edge appears on `out_data`, with `out_valid` high, after that edge.
- R10: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled, `out_data` and `out_valid` hold.
- R11: After reset, `out_valid` is 0, `out_data` is all zeros and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| op_kind | input | 2 | Operand signedness: 0 s×s, 1 s×u, 2 or 3 u×u |
| sat_en | input | 1 | 1 clamps the lane sum, 0 wraps it |
| narrow | input | 1 | 1 activates the lower half of the lanes only |
| acc_vec | input | 32*LANES | Accumulator lanes |
| a_vec | input | 32*LANES | First byte vector |
| b_vec | input | 32*LANES | Second byte vector |
| out_valid | output | 1 | Result register holds a beat |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32*LANES | Packed 32-bit results |

## Verification
The assertions take for granted that `in_valid`, `out_ready`, `narrow`, `sat_en` and the operand vectors carry defined values on every clock edge after reset. The pass-through property also assumes that an all-zero `a_vec` really stands for zero factors in every lane. The bench drives every input to a known value from time zero and keeps `in_valid` low through reset. It changes inputs only at falling edges. It lowers `out_ready` only inside the stall test, so every stalled beat is eventually released.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int LANE_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int BPL      = LANE_W / BYTE_W;   // bytes per lane
  localparam int PROD_W   = 2 * (BYTE_W + 1);  // 9x9 signed product
  localparam int PSUM_W   = PROD_W + 2;        // four products
  localparam int TOT_W    = LANE_W + 4;        // exact lane total with guard bits

  typedef enum logic [1:0] {
    OPK_SS  = 2'd0,
    OPK_SU  = 2'd1,
    OPK_UU  = 2'd2,
    OPK_UU2 = 2'd3
  } opkind_e;
endpackage

// File: rtl/dpb_prod.sv
module dpb_prod
  import dpb_pkg::*;
(
  input  logic [BYTE_W-1:0]        x,
  input  logic [BYTE_W-1:0]        y,
  input  logic                     x_signed,
  input  logic                     y_signed,
  output logic signed [PROD_W-1:0] prod
);
  logic signed [BYTE_W:0] xe, ye;

  always_comb begin
    xe   = {x_signed & x[BYTE_W-1], x};
    ye   = {y_signed & y[BYTE_W-1], y};
    prod = xe * ye;
  end
endmodule

// File: rtl/dpb_clamp.sv
module dpb_clamp
  import dpb_pkg::*;
(
  input  logic [TOT_W-1:0]  total,
  input  logic              sat_en,
  input  logic              unsigned_rng,
  output logic [LANE_W-1:0] res
);
  logic s_fits, u_fits;

  always_comb begin
    // signed fit: all bits from the sign down to bit 31 agree
    s_fits = (total[TOT_W-1:LANE_W-1] == '0) || (total[TOT_W-1:LANE_W-1] == '1);
    u_fits = (total[TOT_W-1:LANE_W] == '0);
    res    = total[LANE_W-1:0];
    if (sat_en) begin
      if (unsigned_rng) begin
        if (!u_fits) res = total[TOT_W-1] ? '0 : '1;
      end else begin
        if (!s_fits) res = total[TOT_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                          : {1'b0, {(LANE_W-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/dpb_lane.sv
module dpb_lane
  import dpb_pkg::*;
(
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] a_w,
  input  logic [LANE_W-1:0] b_w,
  input  logic [1:0]        op_kind,
  input  logic              sat_en,
  output logic [LANE_W-1:0] res
);
  logic                     a_sgn, b_sgn, uns;
  logic signed [PROD_W-1:0] prods [BPL];
  logic signed [PSUM_W-1:0] psum;
  logic [TOT_W-1:0]         acc_ext, total;

  assign uns   = (op_kind == OPK_UU) || (op_kind == OPK_UU2);
  assign a_sgn = !uns;
  assign b_sgn = (op_kind == OPK_SS);

  for (genvar k = 0; k < BPL; k++) begin : g_byte
    dpb_prod u_prod (
      .x        (a_w[k*BYTE_W +: BYTE_W]),
      .y        (b_w[k*BYTE_W +: BYTE_W]),
      .x_signed (a_sgn),
      .y_signed (b_sgn),
      .prod     (prods[k])
    );
  end

  always_comb begin
    psum = '0;
    for (int k = 0; k < BPL; k++) psum = psum + PSUM_W'(prods[k]);
    acc_ext = uns ? {{(TOT_W-LANE_W){1'b0}}, acc}
                  : {{(TOT_W-LANE_W){acc[LANE_W-1]}}, acc};
    total   = acc_ext + {{(TOT_W-PSUM_W){psum[PSUM_W-1]}}, psum};
  end

  dpb_clamp u_clamp (
    .total        (total),
    .sat_en       (sat_en),
    .unsigned_rng (uns),
    .res          (res)
  );
endmodule

// File: rtl/byte_dot_acc.sv
module byte_dot_acc
  import dpb_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              op_kind,
  input  logic                    sat_en,
  input  logic                    narrow,
  input  logic [LANES*LANE_W-1:0] acc_vec,
  input  logic [LANES*LANE_W-1:0] a_vec,
  input  logic [LANES*LANE_W-1:0] b_vec,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int HALF  = LANES / 2;

  logic [VEC_W-1:0] next_data;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    dpb_lane u_lane (
      .acc     (acc_vec[j*LANE_W +: LANE_W]),
      .a_w     (a_vec[j*LANE_W +: LANE_W]),
      .b_w     (b_vec[j*LANE_W +: LANE_W]),
      .op_kind (op_kind),
      .sat_en  (sat_en),
      .res     (lane_res)
    );
    if (j >= HALF) begin : g_upper
      assign next_data[j*LANE_W +: LANE_W] = narrow ? '0 : lane_res;
    end else begin : g_lower
      assign next_data[j*LANE_W +: LANE_W] = lane_res;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/byte_dot_acc_chk.sv
module byte_dot_acc_chk
  import dpb_pkg::*;
#(
  parameter int LANES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    sat_en,
  input logic                    narrow,
  input logic [LANES*LANE_W-1:0] acc_vec,
  input logic [LANES*LANE_W-1:0] a_vec,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] out_data
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int HALF  = VEC_W / 2;

  assert_accept_to_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_drop_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && narrow) |=> (out_data[VEC_W-1:HALF] == '0));

  assert_zero_bytes_pass_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !sat_en && !narrow && a_vec == '0)
      |=> (out_data == $past(acc_vec)));
endmodule

bind byte_dot_acc byte_dot_acc_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .sat_en    (sat_en),
  .narrow    (narrow),
  .acc_vec   (acc_vec),
  .a_vec     (a_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/byte_dot_acc_test.sv
`timescale 1ns/1ps
module byte_dot_acc_test;
  localparam int LANES = 8;
  localparam int VEC_W = LANES * 32;
  localparam int HALF  = LANES / 2;
  localparam int NV    = 17;

  // {kind[1:0], sat, acc, a, b, expected lane}
  localparam logic [130:0] TABLE [NV] = '{
    {2'd0, 1'b0, 32'h00000000, 32'h01020304, 32'h01010101, 32'h0000000A}, // R2 R5
    {2'd0, 1'b0, 32'h00000064, 32'hFFFFFFFF, 32'h02020202, 32'h0000005C}, // R2
    {2'd0, 1'b0, 32'h00000000, 32'h80808080, 32'h80808080, 32'h00010000}, // R2
    {2'd1, 1'b0, 32'h00000000, 32'h80808080, 32'hFFFFFFFF, 32'hFFFE0200}, // R3
    {2'd2, 1'b0, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0003F804}, // R4
    {2'd0, 1'b0, 32'h7FFFFFFF, 32'h01000000, 32'h01000000, 32'h80000000}, // R5
    {2'd0, 1'b1, 32'h7FFFFFFF, 32'h01000000, 32'h01000000, 32'h7FFFFFFF}, // R6
    {2'd0, 1'b1, 32'h80000000, 32'h000000FF, 32'h00000001, 32'h80000000}, // R6
    {2'd0, 1'b0, 32'h80000000, 32'h000000FF, 32'h00000001, 32'h7FFFFFFF}, // R5
    {2'd1, 1'b1, 32'h80000010, 32'h80808080, 32'hFFFFFFFF, 32'h80000000}, // R6
    {2'd2, 1'b1, 32'hFFFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R7
    {2'd2, 1'b0, 32'hFFFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0003F7F4}, // R5
    {2'd1, 1'b1, 32'h7FFFFF00, 32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFFF}, // R6
    {2'd1, 1'b0, 32'h00000000, 32'h01010101, 32'h80808080, 32'h00000200}, // R3
    {2'd0, 1'b0, 32'h00000000, 32'h01010101, 32'h80808080, 32'hFFFFFE00}, // R2
    {2'd2, 1'b0, 32'h00000000, 32'h00000002, 32'h03000000, 32'h00000000}, // R1
    {2'd3, 1'b0, 32'h00000000, 32'h01010101, 32'h80808080, 32'h00000200}  // R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] op_kind = 2'd0;
  logic sat_en = 1'b0, narrow = 1'b0;
  logic [VEC_W-1:0] acc_vec = '0, a_vec = '0, b_vec = '0, out_data;
  logic out_valid, out_ready = 1'b1;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  byte_dot_acc #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_kind(op_kind), .sat_en(sat_en), .narrow(narrow),
    .acc_vec(acc_vec), .a_vec(a_vec), .b_vec(b_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  // behavioural reference for one lane
  function automatic logic [31:0] ref_lane(logic [1:0] k, logic s,
                                           logic [31:0] acc, logic [31:0] a, logic [31:0] b);
    longint sum = 0, tot, av, bv;
    for (int i = 0; i < 4; i++) begin
      av = (k < 2) ? longint'($signed(a[8*i +: 8])) : longint'(a[8*i +: 8]);
      bv = (k == 0) ? longint'($signed(b[8*i +: 8])) : longint'(b[8*i +: 8]);
      sum += av * bv;
    end
    tot = ((k >= 2) ? longint'(acc) : longint'($signed(acc))) + sum;
    if (s) begin
      if (k >= 2) begin
        if (tot < 0) tot = 0;
        if (tot > 64'sd4294967295) tot = 64'sd4294967295;
      end else begin
        if (tot < -64'sd2147483648) tot = -64'sd2147483648;
        if (tot > 64'sd2147483647) tot = 64'sd2147483647;
      end
    end
    return tot[31:0];
  endfunction

  task automatic check(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] k, logic s, logic n,
                      logic [VEC_W-1:0] acc, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b);
    @(negedge clk);
    op_kind = k; sat_en = s; narrow = n;
    acc_vec = acc; a_vec = a; b_vec = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] ra, rb, rc, ex, ex2;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", {{(VEC_W-1){1'b0}}, out_valid}, '0);
    check("R11 out_data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 in_ready", {{(VEC_W-1){1'b0}}, in_ready}, {{(VEC_W-1){1'b0}}, 1'b1});

    // table walk, lane word replicated across all lanes
    for (int i = 0; i < NV; i++) begin
      send(TABLE[i][130:129], TABLE[i][128], 1'b0,
           {LANES{TABLE[i][127:96]}}, {LANES{TABLE[i][95:64]}}, {LANES{TABLE[i][63:32]}});
      check($sformatf("table %0d R1-mode R9", i), out_data, {LANES{TABLE[i][31:0]}});
      check("R9 out_valid", {{(VEC_W-1){1'b0}}, out_valid}, {{(VEC_W-1){1'b0}}, 1'b1});
    end

    // R1: distinct lanes, every mode, pseudo-random patterns
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 6; r++) begin
        for (int j = 0; j < LANES; j++) begin
          rc[32*j +: 32] = rnd(); ra[32*j +: 32] = rnd(); rb[32*j +: 32] = rnd();
          if (r == 0) rc[32*j +: 32] = (m[0]) ? 32'h7FFFFFF0 : 32'hFFFFFFF8;
          ex[32*j +: 32] = ref_lane(m[2:1], m[0], rc[32*j +: 32], ra[32*j +: 32], rb[32*j +: 32]);
        end
        send(m[2:1], m[0], 1'b0, rc, ra, rb);
        check($sformatf("R1 lanes kind=%0d sat=%0d", m[2:1], m[0]), out_data, ex);
      end
    end

    // R8: narrow mode, upper operands carry noise
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < LANES; j++) begin
        rc[32*j +: 32] = rnd(); ra[32*j +: 32] = rnd(); rb[32*j +: 32] = rnd();
        ex[32*j +: 32] = (j < HALF) ? ref_lane(2'(r), 1'b1, rc[32*j +: 32],
                                               ra[32*j +: 32], rb[32*j +: 32]) : 32'h0;
      end
      send(2'(r), 1'b1, 1'b1, rc, ra, rb);
      check("R8 narrow", out_data, ex);
    end

    // R10: stall and release
    for (int j = 0; j < LANES; j++) begin
      ra[32*j +: 32] = rnd(); rb[32*j +: 32] = rnd(); rc[32*j +: 32] = rnd();
      ex[32*j +: 32]  = ref_lane(2'd0, 1'b0, rc[32*j +: 32], ra[32*j +: 32], rb[32*j +: 32]);
      ex2[32*j +: 32] = ref_lane(2'd1, 1'b0, rc[32*j +: 32], rb[32*j +: 32], ra[32*j +: 32]);
    end
    @(negedge clk);
    out_ready = 1'b0;
    op_kind = 2'd0; sat_en = 1'b0; narrow = 1'b0;
    acc_vec = rc; a_vec = ra; b_vec = rb; in_valid = 1'b1;
    @(negedge clk);
    check("R10 stalled in_ready low", {{(VEC_W-1){1'b0}}, in_ready}, '0);
    op_kind = 2'd1; a_vec = rb; b_vec = ra;
    @(negedge clk);
    check("R10 held data", out_data, ex);
    check("R10 held valid", {{(VEC_W-1){1'b0}}, out_valid}, {{(VEC_W-1){1'b0}}, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second beat after release", out_data, ex2);
    @(negedge clk);
    check("R10 drained", {{(VEC_W-1){1'b0}}, out_valid}, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule